// File: doc/BRIEF.md
# Early-Exit Shift-Add Multiplier

This block multiplies two unsigned operands one bit of the multiplier at a time. An operand pair is presented with `start`. It is captured only while `in_ready` is high. The block then repeats a test-and-step loop. Each step adds the multiplicand to the running product when the multiplier's lowest bit is set, shifts the multiplicand one place left and shifts the multiplier one place right. The loop ends as soon as the multiplier register holds zero, so the latency depends on the position of the highest set bit of `b`, not on the operand width.

The control path is a Moore machine whose two-bit state code is driven on `state`. On the input side, `start` with `a` and `b` acts as a valid signal and `in_ready` acts as its ready. A pair transfers on any rising edge where both are high. A `start` seen while `in_ready` is low is ignored and has no effect. The output side has no back-pressure. `valid` is a one-cycle strobe, and the consumer must take `r` in that cycle. `r` then stays unchanged until the next pair is accepted.

Top module: `shiftadd_mul`

## Requirements
- R1: While `rst` (synchronous, active high) is high, and in the cycle after it falls, `state` is 0, `r` is 0, `valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is high exactly when `state` is 0 (idle). The operands are captured on the rising edge where `start` and `in_ready` are both high. Changes to `start`, `a` or `b` while `in_ready` is low do not change the result.
- R3: In the cycle where `valid` is high, `r` equals `a`×`b` (unsigned, width 2×WIDTH) for the captured pair.
- R4: `valid` is high for exactly one cycle per accepted pair, with `state` = 3. In the next cycle `state` is 0 and `in_ready` is 1.
- R5: Let k be the 1-based index of the highest set bit of `b` (k = 0 when `b` = 0). Counting the cycle after the accepting edge as cycle 1, `valid` is high in cycle 2k+2. For WIDTH = 8, 0xFF×0xFF yields 0xFE01 in cycle 18.
- R6: The state codes are 0 = idle, 1 = test, 2 = step and 3 = done. The cycle right after acceptance is always in state 1.
- R7: When `b` is 0, the block skips every step state and raises `valid` in cycle 2 with `r` = 0.
- R8: While idle with `start` low, `r` keeps the last product.
- R9: Each operation spends exactly k cycles in state 2, and each of these cycles is followed by state 1. In every step cycle the multiplier register shifts right by one place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operand pair valid |
| in_ready | output | 1 | Block can accept a pair (idle) |
| a | input | WIDTH | Multiplicand |
| b | input | WIDTH | Multiplier; its highest set bit sets the latency |
| r | output | 2×WIDTH | Product register |
| valid | output | 1 | One-cycle result strobe |
| state | output | 2 | Current controller state code |

## Verification
The bench builds the block with the default WIDTH of 8. It runs every one of the 256 multiplier values against sixteen multiplicands: zero, one, all ones, single-bit values and alternating patterns. Sweeping every `b` reaches every latency from 2 to 18 cycles and every step count from 0 to 8, including the zero-multiplier early exit and the full-length 0xFF×0xFF case. Some operations also assert `start` with altered operands while the block is busy, to show that such input is ignored.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TEST = 2'd1,
    ST_STEP = 2'd2,
    ST_DONE = 2'd3
  } mul_state_e;
endpackage

// File: rtl/mul_shreg.sv
module mul_shreg #(
  parameter int W          = 8,
  parameter bit SHIFT_LEFT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] shifted;

  generate
    if (SHIFT_LEFT) begin : g_left
      assign shifted = {q[W-2:0], 1'b0};
    end else begin : g_right
      assign shifted = {1'b0, q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= shifted;
  end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod,
  output logic           mplier_zero
);
  localparam int PW = 2 * W;

  logic [PW-1:0] mcand_q;
  logic [W-1:0]  mplier_q;
  logic [PW-1:0] sum;
  logic [PW-1:0] prod_d;

  mul_shreg #(.W(PW), .SHIFT_LEFT(1'b1)) u_mcand (
    .clk(clk), .rst(rst), .load(load), .shift(step),
    .din({{W{1'b0}}, a}), .q(mcand_q)
  );

  mul_shreg #(.W(W), .SHIFT_LEFT(1'b0)) u_mplier (
    .clk(clk), .rst(rst), .load(load), .shift(step),
    .din(b), .q(mplier_q)
  );

  assign sum         = prod + mcand_q;
  assign mplier_zero = (mplier_q == '0);

  always_comb begin
    if (load)                   prod_d = '0;
    else if (step && mplier_q[0]) prod_d = sum;
    else                        prod_d = prod;
  end

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= prod_d;
  end

  // R9
  mplier_shift_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (mplier_q == ($past(mplier_q) >> 1)));
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (prod == '0) && (mplier_q == $past(b)));
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import shiftadd_mul_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       mplier_zero,
  output mul_state_e state,
  output logic       in_ready,
  output logic       step,
  output logic       valid
);
  mul_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) nxt = ST_TEST;
      ST_TEST: nxt = mplier_zero ? ST_DONE : ST_STEP;
      ST_STEP: nxt = ST_TEST;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  assign in_ready = (state == ST_IDLE);
  assign step     = (state == ST_STEP);
  assign valid    = (state == ST_DONE);

  // R4
  done_leaves_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_IDLE));
  // R9
  step_returns_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STEP) |=> (state == ST_TEST));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> (state == ST_IDLE));
  // R7
  zero_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TEST && mplier_zero) |=> (state == ST_DONE));
  // R6
  accept_test_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start) |=> (state == ST_TEST));
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
  import shiftadd_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             in_ready,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [2*WIDTH-1:0] r,
  output logic             valid,
  output logic [1:0]       state
);
  localparam int PW = 2 * WIDTH;

  mul_state_e    st;
  logic          step;
  logic          load;
  logic          mplier_zero;
  logic [PW-1:0] prod;

  assign load = start & in_ready;

  mul_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mplier_zero(mplier_zero),
    .state(st), .in_ready(in_ready), .step(step), .valid(valid)
  );

  mul_datapath #(.W(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .a(a), .b(b), .prod(prod), .mplier_zero(mplier_zero)
  );

  assign r     = prod;
  assign state = st;

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R8
  idle_hold_r_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !start) |=> $stable(r));
  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (state == 2'd0));
endmodule

// File: tb/sim_shiftadd_mul.sv
module sim_shiftadd_mul;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  logic          in_ready;
  logic [PW-1:0] r;
  logic          valid;
  logic [1:0]    state;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  shiftadd_mul #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .in_ready(in_ready),
    .a(a), .b(b), .r(r), .valid(valid), .state(state)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int top_bit(input logic [W-1:0] v);
    int k = 0;
    for (int i = 0; i < W; i++) if (v[i]) k = i + 1;
    return k;
  endfunction

  function automatic logic [W-1:0] a_pick(input int i);
    case (i)
      0: return 8'h00;  1: return 8'h01;  2: return 8'hFF;  3: return 8'h03;
      4: return 8'h55;  5: return 8'hAA;  6: return 8'h80;  7: return 8'h7F;
      8: return 8'h0F;  9: return 8'hF0; 10: return 8'h33; 11: return 8'hC3;
      12: return 8'h02; 13: return 8'h40; 14: return 8'h9D; default: return 8'hE6;
    endcase
  endfunction

  task automatic run_op(input logic [W-1:0] ai, input logic [W-1:0] bi,
                        input bit poke);
    int n;
    int steps;
    int k;
    logic [PW-1:0] expv;
    bit timeout;
    k = top_bit(bi);
    expv = PW'(ai) * PW'(bi);
    @(negedge clk);
    check(in_ready === 1'b1, "R2 ready before op", 32'(in_ready), 1);
    a = ai; b = bi; start = 1'b1;
    @(negedge clk);
    n = 1; steps = 0; timeout = 1'b0;
    // R6: first cycle after acceptance is test state
    check(state === 2'd1, "R6 test after accept", 32'(state), 1);
    // R2: busy input poke must be ignored
    check(in_ready === 1'b0, "R2 busy not ready", 32'(in_ready), 0);
    if (poke) begin a = ~ai; b = ~bi; end else start = 1'b0;
    while (!valid) begin
      if (state == 2'd2) steps++;
      if (n > 4 * W + 8) begin timeout = 1'b1; break; end
      @(negedge clk);
      n++;
      if (poke && n == 2) start = 1'b0;
    end
    start = 1'b0;
    check(!timeout, "R4 valid seen", 32'(n), 32'(2 * k + 2));
    check(r === expv, "R3 product", 32'(r), 32'(expv));
    check(n == 2 * k + 2, "R5 latency", 32'(n), 32'(2 * k + 2));
    check(steps == k, "R9 step count", 32'(steps), 32'(k));
    check(state === 2'd3, "R6 done code", 32'(state), 3);
    if (bi == '0)
      check(n == 2 && r === '0, "R7 zero multiplier", 32'(n), 2);
    @(negedge clk);
    check(valid === 1'b0 && state === 2'd0 && in_ready === 1'b1,
          "R4 single strobe", {valid, state, in_ready}, 32'b0_00_1);
    check(r === expv, "R8 r held", 32'(r), 32'(expv));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while held
    check(state === 2'd0 && r === '0 && valid === 1'b0 && in_ready === 1'b1,
          "R1 in reset", {state, valid, in_ready}, 32'b00_0_1);
    rst = 1'b0;
    @(negedge clk);
    check(state === 2'd0 && r === '0 && valid === 1'b0,
          "R1 after reset", 32'(r), 0);
    run_op(8'hFF, 8'hFF, 1'b0);
    run_op(8'h03, 8'h02, 1'b0);
    run_op(8'hFF, 8'h00, 1'b0);
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 256; j++) begin
        run_op(a_pick(i), W'(j), (i % 2 == 1) && (j % 7 == 0));
      end
    end
    // R8: idle hold over several cycles
    repeat (3) @(negedge clk);
    check(r === 16'(PW'(a_pick(15)) * PW'(8'hFF)), "R8 long idle",
          32'(r), 32'(PW'(a_pick(15)) * PW'(8'hFF)));
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule